// File: doc/BRIEF.md
# Paged Register Access Bridge

This block lets a host processor reach a switch-internal register file that is addressed by an 8-bit page and an 8-bit register index. The host sees a small set of 32-bit registers. It takes ownership of the bridge through a request/grant handshake. It loads up to 64 bits of write data through separate high and low windows, then writes one command word that names the page, the register and the direction, with a go bit set. The bridge runs exactly one access on a downstream valid/ready port and waits for a done pulse. A read captures the returned data into two read windows. The go bit reads back as busy until the access is over.

The block also gathers thirteen event sources into a pending register. Each pending bit is cleared by writing one to it. A single host interrupt line is raised when any bit is pending and the host has enabled interrupts. A reset bit in the command word abandons an access that hangs, without disturbing ownership or pending events.

Top module: `pgb_bridge`

## Requirements
- R1: After reset the command word, the control word, the pending register, `irq_out` and `dn_valid` all read as zero.
- R2: The grant (control bit 4, read-only) rises on the second clock edge after a write sets the request bit (control bit 3), and only while no access is busy. It falls on the clock edge after a write clears the request bit.
- R3: A command word (offset 0x2C) written while the grant is low starts no downstream access and leaves the command word readback unchanged.
- R4: A command written while busy is ignored, so the access already in progress keeps its page and register. Only one downstream access is outstanding at a time.
- R5: A command with go (bit 0) and write (bit 1) set presents page (bits 31:24), register (bits 23:16), write=1 and data {high window 0x30, low window 0x34} downstream. Busy (command bit 0) stays set until the done pulse and then clears.
- R6: A command with go set and write clear returns the downstream read data in the low window 0x3C (bits 31:0) and the high window 0x38 (bits 63:32) once busy has cleared.
- R7: Writing the command word with bit 2 set aborts any access: busy and `dn_valid` are low on the next cycle, while the grant and the pending bits are kept.
- R8: An event on `evt_in[i]` sets pending bit i at offset 0x44. Writing ones there clears exactly those bits, and writing all ones clears every bit.
- R9: An event that arrives in the same cycle as a clear of its own bit leaves that bit pending.
- R10: `irq_out` is high exactly when control bit 1 (interrupt enable) is set and at least one bit is pending.
- R11: While `dn_valid` is high and `dn_ready` is low, the valid line, page, register, direction and write data stay stable.
- R12: Control bit 6 is a plain host flag that reads back as it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Host write strobe |
| bus_waddr | input | ADDR_W | Host write byte offset |
| bus_wdata | input | BUS_W | Host write data |
| bus_raddr | input | ADDR_W | Host read byte offset |
| bus_rdata | output | BUS_W | Host read data (combinational) |
| dn_valid | output | 1 | Downstream access request |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_page | output | PAGE_W | Downstream page |
| dn_reg | output | REG_W | Downstream register index |
| dn_write | output | 1 | 1 = write, 0 = read |
| dn_wdata | output | 2*BUS_W | Downstream write data |
| dn_done | input | 1 | Downstream completion pulse |
| dn_rdata | input | 2*BUS_W | Downstream read data, valid with done |
| evt_in | input | NSRC | Event pulses, one per source |
| irq_out | output | 1 | Host interrupt |

## Verification
The bench sweeps every page and register of a 4 by 8 corner of the address space. Each location is written with a distinct 64-bit pattern and then read back, with the ready stall and the done latency varied per location. A swapped byte lane, a wrong field offset or a lost high word therefore shows up as a mismatch on a specific location. Each of the thirteen event sources is pulsed alone with the enable alternating, which separates a bit-position fault from a gating fault. Collision cases are exercised separately: an event coinciding with its own clear, a command during busy, a command without ownership, a re-request while an orphaned access is in flight, and an abort.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
   // host register byte offsets
   localparam logic [7:0] OFS_CMD = 8'h2C;
   localparam logic [7:0] OFS_WDH = 8'h30;
   localparam logic [7:0] OFS_WDL = 8'h34;
   localparam logic [7:0] OFS_RDH = 8'h38;
   localparam logic [7:0] OFS_RDL = 8'h3C;
   localparam logic [7:0] OFS_CTL = 8'h40;
   localparam logic [7:0] OFS_IRQ = 8'h44;

   // command word fields
   localparam int CMD_GO       = 0;
   localparam int CMD_WR       = 1;
   localparam int CMD_ABORT    = 2;
   localparam int CMD_REG_LSB  = 16;
   localparam int CMD_PAGE_LSB = 24;

   // control word fields
   localparam int CTL_IEN  = 1;
   localparam int CTL_REQ  = 3;
   localparam int CTL_GNT  = 4;
   localparam int CTL_INIT = 6;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_WAIT  = 2'd2
   } sq_state_t;
endpackage

// File: rtl/pgb_grant.sv
module pgb_grant (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic busy,
   output logic grant
);
   logic grant_q;

   // ownership is handed out only when no access is in flight,
   // and is kept while the request stays up
   always_ff @(posedge clk) begin
      if (!rst_n) grant_q <= 1'b0;
      else        grant_q <= req && (grant_q || !busy);
   end

   assign grant = grant_q;
endmodule

// File: rtl/pgb_seq.sv
module pgb_seq
   import pgb_pkg::*;
#(
   parameter int PAGE_W = 8,
   parameter int REG_W  = 8,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              grant,
   input  logic [PAGE_W-1:0] cmd_page,
   input  logic [REG_W-1:0]  cmd_reg,
   input  logic              cmd_wr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [PAGE_W-1:0] dn_page,
   output logic [REG_W-1:0]  dn_reg,
   output logic              dn_write,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_done,
   input  logic [DATA_W-1:0] dn_rdata,
   output logic [DATA_W-1:0] rd_data
);
   sq_state_t         state_q;
   logic [PAGE_W-1:0] page_q;
   logic [REG_W-1:0]  reg_q;
   logic              wr_q;
   logic [DATA_W-1:0] wd_q;
   logic [DATA_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         page_q  <= '0;
         reg_q   <= '0;
         wr_q    <= 1'b0;
         wd_q    <= '0;
         rd_q    <= '0;
      end else if (abort) begin
         state_q <= SQ_IDLE;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (start && grant) begin
                  state_q <= SQ_ISSUE;
                  page_q  <= cmd_page;
                  reg_q   <= cmd_reg;
                  wr_q    <= cmd_wr;
                  wd_q    <= wr_data;
               end
            end
            SQ_ISSUE: begin
               if (dn_ready) state_q <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (dn_done) begin
                  state_q <= SQ_IDLE;
                  if (!wr_q) rd_q <= dn_rdata;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != SQ_IDLE);
   assign dn_valid = (state_q == SQ_ISSUE);
   assign dn_page  = page_q;
   assign dn_reg   = reg_q;
   assign dn_write = wr_q;
   assign dn_wdata = wd_q;
   assign rd_data  = rd_q;
endmodule

// File: rtl/pgb_irq.sv
module pgb_irq #(
   parameter int NSRC    = 13,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt,
   input  logic            clr_we,
   input  logic [NSRC-1:0] clr_mask,
   input  logic            en,
   output logic [NSRC-1:0] pending,
   output logic            irq
);
   logic [NSRC-1:0] pend_q;
   logic [NSRC-1:0] clr_eff;
   logic            irq_raw;

   assign clr_eff = clr_we ? clr_mask : '0;

   // a fresh event is ORed in after the clear, so it wins a collision
   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_eff) | evt;
   end

   assign irq_raw = en && (|pend_q);
   assign pending = pend_q;

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate
endmodule

// File: rtl/pgb_bridge.sv
module pgb_bridge
   import pgb_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int BUS_W   = 32,
   parameter int PAGE_W  = 8,
   parameter int REG_W   = 8,
   parameter int NSRC    = 13,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wen,
   input  logic [ADDR_W-1:0]    bus_waddr,
   input  logic [BUS_W-1:0]     bus_wdata,
   input  logic [ADDR_W-1:0]    bus_raddr,
   output logic [BUS_W-1:0]     bus_rdata,
   output logic                 dn_valid,
   input  logic                 dn_ready,
   output logic [PAGE_W-1:0]    dn_page,
   output logic [REG_W-1:0]     dn_reg,
   output logic                 dn_write,
   output logic [2*BUS_W-1:0]   dn_wdata,
   input  logic                 dn_done,
   input  logic [2*BUS_W-1:0]   dn_rdata,
   input  logic [NSRC-1:0]      evt_in,
   output logic                 irq_out
);
   localparam int DATA_W = 2 * BUS_W;
   localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFS_CMD);
   localparam logic [ADDR_W-1:0] A_WDH = ADDR_W'(OFS_WDH);
   localparam logic [ADDR_W-1:0] A_WDL = ADDR_W'(OFS_WDL);
   localparam logic [ADDR_W-1:0] A_RDH = ADDR_W'(OFS_RDH);
   localparam logic [ADDR_W-1:0] A_RDL = ADDR_W'(OFS_RDL);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
   localparam logic [ADDR_W-1:0] A_IRQ = ADDR_W'(OFS_IRQ);

   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("pgb_bridge: ADDR_W must cover offset 0x44");
      end
      if (BUS_W < 32) begin : g_bad_bus
         $error("pgb_bridge: BUS_W must be at least 32");
      end
      if (PAGE_W < 1 || PAGE_W > 8 || REG_W < 1 || REG_W > 8) begin : g_bad_fld
         $error("pgb_bridge: page and register fields are 1 to 8 bits");
      end
      if (NSRC < 1 || NSRC > BUS_W) begin : g_bad_src
         $error("pgb_bridge: NSRC must fit in one host word");
      end
   endgenerate

   // write decode
   logic wr_cmd, wr_wdh, wr_wdl, wr_ctl, wr_irq;
   assign wr_cmd = bus_wen && (bus_waddr == A_CMD);
   assign wr_wdh = bus_wen && (bus_waddr == A_WDH);
   assign wr_wdl = bus_wen && (bus_waddr == A_WDL);
   assign wr_ctl = bus_wen && (bus_waddr == A_CTL);
   assign wr_irq = bus_wen && (bus_waddr == A_IRQ);

   logic start, abort;
   assign abort = wr_cmd && bus_wdata[CMD_ABORT];
   assign start = wr_cmd && bus_wdata[CMD_GO] && !bus_wdata[CMD_ABORT];

   // host-owned state
   logic             host_req, ien_q, init_q;
   logic [BUS_W-1:0] wdh_q, wdl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_req <= 1'b0;
         ien_q    <= 1'b0;
         init_q   <= 1'b0;
         wdh_q    <= '0;
         wdl_q    <= '0;
      end else begin
         if (wr_ctl) begin
            host_req <= bus_wdata[CTL_REQ];
            ien_q    <= bus_wdata[CTL_IEN];
            init_q   <= bus_wdata[CTL_INIT];
         end
         if (wr_wdh) wdh_q <= bus_wdata;
         if (wr_wdl) wdl_q <= bus_wdata;
      end
   end

   logic              busy, grant;
   logic [DATA_W-1:0] rd_data;
   logic [NSRC-1:0]   pending;

   pgb_grant u_grant (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (host_req),
      .busy  (busy),
      .grant (grant)
   );

   pgb_seq #(
      .PAGE_W (PAGE_W),
      .REG_W  (REG_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .abort    (abort),
      .grant    (grant),
      .cmd_page (bus_wdata[CMD_PAGE_LSB +: PAGE_W]),
      .cmd_reg  (bus_wdata[CMD_REG_LSB +: REG_W]),
      .cmd_wr   (bus_wdata[CMD_WR]),
      .wr_data  ({wdh_q, wdl_q}),
      .busy     (busy),
      .dn_valid (dn_valid),
      .dn_ready (dn_ready),
      .dn_page  (dn_page),
      .dn_reg   (dn_reg),
      .dn_write (dn_write),
      .dn_wdata (dn_wdata),
      .dn_done  (dn_done),
      .dn_rdata (dn_rdata),
      .rd_data  (rd_data)
   );

   pgb_irq #(
      .NSRC    (NSRC),
      .IRQ_REG (IRQ_REG)
   ) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_in),
      .clr_we   (wr_irq),
      .clr_mask (bus_wdata[NSRC-1:0]),
      .en       (ien_q),
      .pending  (pending),
      .irq      (irq_out)
   );

   // readback
   logic [BUS_W-1:0] cmd_rb, ctl_rb;
   always_comb begin
      cmd_rb = '0;
      cmd_rb[CMD_PAGE_LSB +: PAGE_W] = dn_page;
      cmd_rb[CMD_REG_LSB +: REG_W]   = dn_reg;
      cmd_rb[CMD_WR]                 = dn_write;
      cmd_rb[CMD_GO]                 = busy;
      ctl_rb = '0;
      ctl_rb[CTL_IEN]  = ien_q;
      ctl_rb[CTL_REQ]  = host_req;
      ctl_rb[CTL_GNT]  = grant;
      ctl_rb[CTL_INIT] = init_q;
   end

   always_comb begin
      case (bus_raddr)
         A_CMD:   bus_rdata = cmd_rb;
         A_WDH:   bus_rdata = wdh_q;
         A_WDL:   bus_rdata = wdl_q;
         A_RDH:   bus_rdata = rd_data[DATA_W-1:BUS_W];
         A_RDL:   bus_rdata = rd_data[BUS_W-1:0];
         A_CTL:   bus_rdata = ctl_rb;
         A_IRQ:   bus_rdata = BUS_W'(pending);
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pgb_checker.sv
module pgb_checker
   import pgb_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BUS_W  = 32,
   parameter int PAGE_W = 8,
   parameter int REG_W  = 8,
   parameter int NSRC   = 13
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wen,
   input logic [ADDR_W-1:0]  bus_waddr,
   input logic [BUS_W-1:0]   bus_wdata,
   input logic               dn_valid,
   input logic               dn_ready,
   input logic [PAGE_W-1:0]  dn_page,
   input logic [REG_W-1:0]   dn_reg,
   input logic               dn_write,
   input logic [2*BUS_W-1:0] dn_wdata,
   input logic               dn_done,
   input logic               busy,
   input logic               grant,
   input logic               req,
   input logic               ien,
   input logic [NSRC-1:0]    pending,
   input logic [NSRC-1:0]    evt_in,
   input logic               irq_out
);
   logic abort_w, clr_w;
   assign abort_w = bus_wen && (bus_waddr == ADDR_W'(OFS_CMD)) && bus_wdata[CMD_ABORT];
   assign clr_w   = bus_wen && (bus_waddr == ADDR_W'(OFS_IRQ));

   p_grant_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !grant);

   p_grant_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant) |-> !$past(busy));

   p_owned_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dn_valid) |-> $past(grant));

   p_busy_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(dn_page) && $stable(dn_reg) && $stable(dn_write)));

   p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(dn_done || abort_w));

   p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_w |=> (!busy && !dn_valid));

   p_evt_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_in) |=> ((pending & $past(evt_in)) == $past(evt_in)));

   p_clr_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && ((evt_in & bus_wdata[NSRC-1:0]) == '0))
         |=> ((pending & $past(bus_wdata[NSRC-1:0])) == '0));

   p_ien_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien && !$past(ien)) |-> !irq_out);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready && !abort_w) |=>
         (dn_valid && $stable(dn_page) && $stable(dn_reg)
          && $stable(dn_write) && $stable(dn_wdata)));
endmodule

bind pgb_bridge pgb_checker #(
   .ADDR_W (ADDR_W),
   .BUS_W  (BUS_W),
   .PAGE_W (PAGE_W),
   .REG_W  (REG_W),
   .NSRC   (NSRC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wen   (bus_wen),
   .bus_waddr (bus_waddr),
   .bus_wdata (bus_wdata),
   .dn_valid  (dn_valid),
   .dn_ready  (dn_ready),
   .dn_page   (dn_page),
   .dn_reg    (dn_reg),
   .dn_write  (dn_write),
   .dn_wdata  (dn_wdata),
   .dn_done   (dn_done),
   .busy      (busy),
   .grant     (grant),
   .req       (host_req),
   .ien       (ien_q),
   .pending   (pending),
   .evt_in    (evt_in),
   .irq_out   (irq_out)
);

// File: tb/tb_pgb_bridge.sv
`timescale 1ns/1ps
module tb_pgb_bridge;
   localparam logic [7:0] A_CMD = 8'h2C, A_WDH = 8'h30, A_WDL = 8'h34,
                          A_RDH = 8'h38, A_RDL = 8'h3C, A_CTL = 8'h40, A_IRQ = 8'h44;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wen = 1'b0;
   logic [7:0]  bus_waddr = '0;
   logic [31:0] bus_wdata = '0;
   logic [7:0]  bus_raddr = '0;
   logic [31:0] bus_rdata;
   logic        dn_valid;
   logic        dn_ready = 1'b0;
   logic [7:0]  dn_page;
   logic [7:0]  dn_reg;
   logic        dn_write;
   logic [63:0] dn_wdata;
   logic        dn_done = 1'b0;
   logic [63:0] dn_rdata = '0;
   logic [12:0] evt_in = '0;
   logic        irq_out;

   always #2 clk = ~clk;

   pgb_bridge dut (
      .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_waddr(bus_waddr),
      .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_page(dn_page), .dn_reg(dn_reg),
      .dn_write(dn_write), .dn_wdata(dn_wdata), .dn_done(dn_done), .dn_rdata(dn_rdata),
      .evt_in(evt_in), .irq_out(irq_out)
   );

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   // downstream model: small register memory
   logic [63:0] mem [0:31];
   int          stall_cfg = 0;
   int          lat_cfg = 1;
   int          m_cnt = 0;
   int          m_stall = 0;
   int          acc_cnt = 0;
   logic [7:0]  last_page = '0;
   logic [7:0]  last_reg = '0;
   logic        last_wr = 1'b0;
   logic [63:0] last_wdata = '0;

   always @(negedge clk) begin
      if (!rst_n) begin
         dn_ready = 1'b0; dn_done = 1'b0; m_cnt = 0; m_stall = 0;
      end else begin
         if (dn_done) dn_done = 1'b0;
         if (dn_ready) begin
            dn_ready   = 1'b0;
            acc_cnt++;
            last_page  = dn_page;
            last_reg   = dn_reg;
            last_wr    = dn_write;
            last_wdata = dn_wdata;
            if (dn_write) mem[{dn_page[1:0], dn_reg[2:0]}] = dn_wdata;
            m_cnt = lat_cfg;
         end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
               dn_done  = 1'b1;
               dn_rdata = mem[{last_page[1:0], last_reg[2:0]}];
            end
         end else if (dn_valid) begin
            if (m_stall >= stall_cfg) begin dn_ready = 1'b1; m_stall = 0; end
            else m_stall++;
         end
      end
   end

   function automatic logic [63:0] pat(int p, int r);
      return 64'h0F1E_2D3C_4B5A_6978 + (64'(p) << 40) + (64'(r) << 8)
             + 64'(p * 8 + r) * 64'h0001_0000_0001;
   endfunction

   task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d, logic [12:0] ev = '0);
      @(negedge clk);
      bus_wen = 1'b1; bus_waddr = a; bus_wdata = d; evt_in = ev;
      @(negedge clk);
      bus_wen = 1'b0; evt_in = '0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_raddr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse(logic [12:0] ev);
      @(negedge clk); evt_in = ev;
      @(negedge clk); evt_in = '0;
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] cmdw(int p, int r, bit w);
      return {8'(p), 8'(r), 13'd0, 1'b0, w, 1'b1};
   endfunction

   task automatic wait_idle(string req);
      logic [31:0] v;
      for (int i = 0; i < 300; i++) begin
         rd(A_CMD, v);
         if (!v[0]) return;
         @(negedge clk);
      end
      chk(req, 64'd1, 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog (R5) got=hung exp=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, lo, hi;
      int          base;
      for (int i = 0; i < 32; i++) mem[i] = '0;
      cyc(5);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CMD, v); chk("R1 cmd", v, 0);
      rd(A_CTL, v); chk("R1 ctl", v, 0);
      rd(A_IRQ, v); chk("R1 pending", v, 0);
      chk("R1 irq_out", irq_out, 0);
      chk("R1 dn_valid", dn_valid, 0);

      // R3 command without grant
      wr(A_CMD, cmdw(2, 3, 1'b0));
      cyc(5);
      chk("R3 no access", acc_cnt, 0);
      rd(A_CMD, v); chk("R3 cmd unchanged", v, 0);

      // R12 flag, R2 grant timing
      wr(A_CTL, 32'h40);
      rd(A_CTL, v); chk("R12 init flag", v, 32'h40);
      wr(A_CTL, 32'h48);
      rd(A_CTL, v); chk("R2 grant not yet", v, 32'h48);
      @(negedge clk);
      rd(A_CTL, v); chk("R2 grant up", v, 32'h58);

      // R5 write sweep
      for (int p = 0; p < 4; p++) begin
         for (int r = 0; r < 8; r++) begin
            logic [63:0] d;
            d = pat(p, r);
            stall_cfg = (p + r) % 3;
            lat_cfg = 1 + (r % 3);
            wr(A_WDL, d[31:0]);
            wr(A_WDH, d[63:32]);
            wr(A_CMD, cmdw(p, r, 1'b1));
            wait_idle("R5 busy");
            chk("R5 fields", {last_page, last_reg, 7'd0, last_wr}, {8'(p), 8'(r), 8'd1});
            chk("R5 wdata", last_wdata, d);
         end
      end

      // R6 read sweep
      for (int p = 0; p < 4; p++) begin
         for (int r = 0; r < 8; r++) begin
            stall_cfg = (p * 3 + r) % 4;
            lat_cfg = 1 + ((p + r) % 4);
            wr(A_CMD, cmdw(p, r, 1'b0));
            wait_idle("R6 busy");
            rd(A_RDL, lo); rd(A_RDH, hi);
            chk("R6 read data", {hi, lo}, pat(p, r));
         end
      end

      // R4 command while busy
      base = acc_cnt;
      stall_cfg = 4; lat_cfg = 2;
      wr(A_CMD, cmdw(1, 2, 1'b0));
      wr(A_CMD, cmdw(3, 5, 1'b1));
      rd(A_CMD, v); chk("R4 cmd kept", v[31:16], 16'h0102);
      wait_idle("R4 busy");
      chk("R4 one access", acc_cnt - base, 1);
      chk("R4 target", {last_page, last_reg, 7'd0, last_wr}, {8'd1, 8'd2, 8'd0});
      chk("R4 no write", mem[{2'd3, 3'd5}], pat(3, 5));

      // R2 grant withheld while an access is in flight
      stall_cfg = 0; lat_cfg = 20;
      wr(A_CMD, cmdw(0, 0, 1'b0));
      cyc(3);
      wr(A_CTL, 32'h40);
      @(negedge clk);
      rd(A_CTL, v); chk("R2 grant drops", v[4], 0);
      wr(A_CTL, 32'h48);
      cyc(3);
      rd(A_CTL, v); chk("R2 no grant while busy", v[4], 0);
      rd(A_CMD, v); chk("R2 still busy", v[0], 1);
      wait_idle("R2 busy");
      @(negedge clk);
      rd(A_CTL, v); chk("R2 grant after idle", v[4], 1);

      // R7 abort
      pulse(13'h008);
      wr(A_CMD, cmdw(1, 1, 1'b0));
      cyc(3);
      wr(A_CMD, 32'h4);
      rd(A_CMD, v); chk("R7 busy cleared", v[0], 0);
      chk("R7 valid low", dn_valid, 0);
      rd(A_CTL, v); chk("R7 grant kept", v[4], 1);
      rd(A_IRQ, v); chk("R7 pending kept", v, 32'h8);
      cyc(30);
      lat_cfg = 1;
      wr(A_CMD, cmdw(1, 1, 1'b0));
      wait_idle("R7 busy");
      rd(A_RDL, lo); rd(A_RDH, hi);
      chk("R7 works after abort", {hi, lo}, pat(1, 1));
      wr(A_IRQ, 32'hFFFF_FFFF);

      // R8 / R10 per-source sweep
      for (int i = 0; i < 13; i++) begin
         bit en;
         en = i[0];
         wr(A_CTL, en ? 32'h4A : 32'h48);
         pulse(13'(1 << i));
         rd(A_IRQ, v); chk("R8 single source", v, 32'(1 << i));
         chk("R10 irq gate", irq_out, en);
         wr(A_IRQ, 32'(1 << i));
         rd(A_IRQ, v); chk("R8 cleared", v, 0);
         chk("R10 irq idle", irq_out, 0);
      end

      // R8 all sources, clear all
      pulse(13'h1FFF);
      rd(A_IRQ, v); chk("R8 all set", v, 32'h1FFF);
      chk("R10 irq all", irq_out, 0);
      wr(A_IRQ, 32'hFFFF_FFFF);
      rd(A_IRQ, v); chk("R8 all cleared", v, 0);

      // R9 event collides with clear
      wr(A_CTL, 32'h4A);
      pulse(13'h060);
      wr(A_IRQ, 32'h60, 13'h020);
      rd(A_IRQ, v); chk("R9 event wins", v, 32'h20);
      chk("R10 irq on", irq_out, 1);
      wr(A_CTL, 32'h48);
      chk("R10 irq off", irq_out, 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule